// File: doc/BRIEF.md
# Biphase Manchester Word Encoder with Loopback Steering

This block turns a 16-bit parallel word into a serial biphase (Manchester II) frame for a dual-redundant serial bus. Each frame opens with a three-bit-time synchronization field whose polarity marks the word as a command/status word or a data word. The sixteen data bits follow, most significant first, and an odd-parity bit closes the frame. A single holding register stands in front of the shifter, so the next word can be handed over while the current one is still going out. Frames then follow one another with no gap.

The encoded stream goes to exactly one destination. When the line is in normal use, that is the complementary line pair of channel A or of channel B. In loopback self-test it is instead the internal receive path of channel A or of channel B, and in that case both external line pairs stay at null. The destination is chosen from the control inputs at the moment a frame starts and is kept for the whole frame. With a 12 MHz clock, a bit cell is 12 clocks (1 Mb/s) and a half-bit is 6 clocks.

Top module: `biphaseEncoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every line output, both loopback outputs, `busy` and `done` are 0.
- R2: A start accepted at clock edge E loads the holding register, and the frame begins at edge E+1. `busy` is then 1 for exactly 40 half-bits of 6 clocks each (240 clocks).
- R3: The sync field is 6 half-bits long. When `syncIsCmd`=1 the line is high for the first 3 half-bits and low for the next 3. When `syncIsCmd`=0 it is low for the first 3 and high for the next 3.
- R4: The 16 data bits follow the sync field, bit 15 first. Each bit takes two half-bits: a 1 is sent high then low, and a 0 is sent low then high.
- R5: The last bit cell (half-bits 38 and 39) carries a parity bit, encoded like a data bit. It is set so that the 16 data bits plus the parity bit hold an odd number of ones.
- R6: On the channel that carries the frame, the negative output is the inverse of the positive output in every cycle of the frame. Outside a frame, both outputs of both channels are 0 (null).
- R7: With `selfTest`=0, the frame goes to channel A if `chanAEn`=1. Otherwise it goes to channel B if `chanBEn`=1. Otherwise it goes nowhere, although the frame is still timed. The channel that is not used stays null.
- R8: With `selfTest`=1, the positive stream appears on `loopA` if `testSelA`=1 and on `loopB` if `testSelA`=0. All four external line outputs stay 0, whatever the channel enables say.
- R9: The destination is sampled when the frame begins. Changing `selfTest`, `testSelA`, `chanAEn` or `chanBEn` during a frame has no effect on that frame.
- R10: A start accepted while a frame is going out, with the holding register empty, makes the held word's frame begin in the clock cycle right after the current frame's last half-bit.
- R11: A start arriving while the holding register is full is ignored: no extra frame is ever sent for it.
- R12: `done` is a single-cycle pulse in the cycle right after the parity bit's second half-bit. If no word is held, `busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz clock |
| rstN | input | 1 | Active-low synchronous reset |
| wordIn | input | 16 | Word to send |
| syncIsCmd | input | 1 | 1 selects the command/status sync, 0 the data sync |
| start | input | 1 | One-cycle request to take `wordIn` |
| selfTest | input | 1 | 1 sends the frame to a loopback path only |
| testSelA | input | 1 | Loopback channel: 1 for A, 0 for B |
| chanAEn | input | 1 | Channel A line enable |
| chanBEn | input | 1 | Channel B line enable |
| txAPos | output | 1 | Channel A biphase, true phase |
| txANeg | output | 1 | Channel A biphase, inverted phase |
| txBPos | output | 1 | Channel B biphase, true phase |
| txBNeg | output | 1 | Channel B biphase, inverted phase |
| loopA | output | 1 | Loopback stream into channel A receive path |
| loopB | output | 1 | Loopback stream into channel B receive path |
| busy | output | 1 | A frame is going out |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Some rules are checked on every cycle: at most one destination is ever active, the line pairs are never both high, the external lines stay null while a loopback frame runs, every output is null outside a frame, a start that meets a full holding register leaves the held word untouched, and `done` lasts one cycle and accompanies the fall of `busy`. The exact half-bit waveform cannot be covered by those cycle rules and is left to the bench scenarios. That waveform covers both sync polarities, the MSB-first order, the parity value and the mid-bit transitions. The bench scenarios also show that the destination is latched despite control changes mid-frame, that a second frame follows back-to-back with no gap, and that a third start is dropped.

// File: rtl/biphaseEncPkg.sv
package biphaseEncPkg;
  // Which part of the frame the current half-bit belongs to
  typedef enum logic [1:0] {
    SEG_LEAD  = 2'd0,
    SEG_TRAIL = 2'd1,
    SEG_DATA  = 2'd2,
    SEG_PAR   = 2'd3
  } segT;

  // Destination of the encoded stream, latched per frame
  typedef enum logic [2:0] {
    DST_NONE   = 3'd0,
    DST_LINE_A = 3'd1,
    DST_LINE_B = 3'd2,
    DST_LOOP_A = 3'd3,
    DST_LOOP_B = 3'd4
  } dstT;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic launch;      // load shifter from holding register, latch route
    logic shift;       // advance to next data bit
    logic live;        // a frame is on the wire
    logic secondHalf;  // second half of a bit cell
    segT  seg;
  } strobeT;
endpackage

// File: rtl/biphaseEncCtrl.sv
module biphaseEncCtrl
  import biphaseEncPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HALF_CLKS   = 6,
  parameter int SYNC_HALVES = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   holdFull,
  output strobeT stb,
  output logic   busy,
  output logic   done
);
  localparam int TOTAL_HALVES = 2 * SYNC_HALVES + 2 * (DATA_W + 1);
  localparam int HALF_W       = $clog2(TOTAL_HALVES);
  localparam int CNT_W        = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam int DATA_BASE    = 2 * SYNC_HALVES;
  localparam int PAR_BASE     = DATA_BASE + 2 * DATA_W;

  logic              active;
  logic [CNT_W-1:0]  clkCnt;
  logic [HALF_W-1:0] halfIdx;
  logic [HALF_W-1:0] relIdx;
  logic              halfEnd;
  logic              frameEnd;
  logic              launch;
  segT               seg;

  assign halfEnd  = active && (clkCnt == CNT_W'(HALF_CLKS - 1));
  assign frameEnd = halfEnd && (halfIdx == HALF_W'(TOTAL_HALVES - 1));
  assign launch   = holdFull && (!active || frameEnd);
  assign relIdx   = halfIdx - HALF_W'(DATA_BASE);

  always_comb begin
    if (halfIdx < HALF_W'(SYNC_HALVES))    seg = SEG_LEAD;
    else if (halfIdx < HALF_W'(DATA_BASE)) seg = SEG_TRAIL;
    else if (halfIdx < HALF_W'(PAR_BASE))  seg = SEG_DATA;
    else                                   seg = SEG_PAR;
  end

  always_comb begin
    stb.launch     = launch;
    stb.live       = active;
    stb.seg        = seg;
    stb.secondHalf = relIdx[0];
    stb.shift      = halfEnd && (seg == SEG_DATA) && relIdx[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      clkCnt  <= '0;
      halfIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= frameEnd;
      if (launch) begin
        active  <= 1'b1;
        clkCnt  <= '0;
        halfIdx <= '0;
      end else if (frameEnd) begin
        active  <= 1'b0;
        clkCnt  <= '0;
        halfIdx <= '0;
      end else if (active) begin
        if (halfEnd) begin
          clkCnt  <= '0;
          halfIdx <= halfIdx + HALF_W'(1);
        end else begin
          clkCnt <= clkCnt + CNT_W'(1);
        end
      end
    end
  end

  assign busy = active;

  // R2
  half_index_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (halfIdx < HALF_W'(TOTAL_HALVES)));

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
endmodule

// File: rtl/biphaseEncPath.sv
module biphaseEncPath
  import biphaseEncPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wordIn,
  input  logic              syncIsCmd,
  input  logic              start,
  input  logic              selfTest,
  input  logic              testSelA,
  input  logic              chanAEn,
  input  logic              chanBEn,
  input  strobeT            stb,
  output logic              holdFull,
  output logic              txAPos,
  output logic              txANeg,
  output logic              txBPos,
  output logic              txBNeg,
  output logic              loopA,
  output logic              loopB
);
  logic [DATA_W-1:0] holdWord;
  logic              holdSync;
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic              frameSync;
  dstT               route;
  dstT               nextRoute;
  logic              accept;
  logic              bitVal;
  logic              lineBit;

  assign accept = start && !holdFull;

  always_comb begin
    if (selfTest)     nextRoute = testSelA ? DST_LOOP_A : DST_LOOP_B;
    else if (chanAEn) nextRoute = DST_LINE_A;
    else if (chanBEn) nextRoute = DST_LINE_B;
    else              nextRoute = DST_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdFull  <= 1'b0;
      holdWord  <= '0;
      holdSync  <= 1'b0;
      shiftReg  <= '0;
      parBit    <= 1'b0;
      frameSync <= 1'b0;
      route     <= DST_NONE;
    end else begin
      if (accept) begin
        holdFull <= 1'b1;
        holdWord <= wordIn;
        holdSync <= syncIsCmd;
      end else if (stb.launch) begin
        holdFull <= 1'b0;
      end
      if (stb.launch) begin
        shiftReg  <= holdWord;
        parBit    <= ~^holdWord;
        frameSync <= holdSync;
        route     <= nextRoute;
      end else if (stb.shift) begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign bitVal = (stb.seg == SEG_PAR) ? parBit : shiftReg[DATA_W-1];

  always_comb begin
    case (stb.seg)
      SEG_LEAD:  lineBit = frameSync;
      SEG_TRAIL: lineBit = ~frameSync;
      default:   lineBit = stb.secondHalf ? ~bitVal : bitVal;
    endcase
  end

  assign txAPos = stb.live && (route == DST_LINE_A) && lineBit;
  assign txANeg = stb.live && (route == DST_LINE_A) && !lineBit;
  assign txBPos = stb.live && (route == DST_LINE_B) && lineBit;
  assign txBNeg = stb.live && (route == DST_LINE_B) && !lineBit;
  assign loopA  = stb.live && (route == DST_LOOP_A) && lineBit;
  assign loopB  = stb.live && (route == DST_LOOP_B) && lineBit;

  // R6
  pair_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txAPos && txANeg) && !(txBPos && txBNeg));

  // R6
  idle_null_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.live |-> !(txAPos || txANeg || txBPos || txBNeg || loopA || loopB));

  // R7
  single_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txAPos || txANeg, txBPos || txBNeg, loopA, loopB}));

  // R8
  loop_quiet_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loopA || loopB) |-> !(txAPos || txANeg || txBPos || txBNeg));

  // R11
  full_hold_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && start) |=> $stable(holdWord));
endmodule

// File: rtl/biphaseEncoder.sv
module biphaseEncoder
  import biphaseEncPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int HALF_CLKS   = 6,
  parameter int SYNC_HALVES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wordIn,
  input  logic              syncIsCmd,
  input  logic              start,
  input  logic              selfTest,
  input  logic              testSelA,
  input  logic              chanAEn,
  input  logic              chanBEn,
  output logic              txAPos,
  output logic              txANeg,
  output logic              txBPos,
  output logic              txBNeg,
  output logic              loopA,
  output logic              loopB,
  output logic              busy,
  output logic              done
);
  strobeT stb;
  logic   holdFull;

  biphaseEncCtrl #(
    .DATA_W(DATA_W), .HALF_CLKS(HALF_CLKS), .SYNC_HALVES(SYNC_HALVES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .holdFull(holdFull),
    .stb(stb), .busy(busy), .done(done)
  );

  biphaseEncPath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .syncIsCmd(syncIsCmd),
    .start(start), .selfTest(selfTest), .testSelA(testSelA),
    .chanAEn(chanAEn), .chanBEn(chanBEn), .stb(stb), .holdFull(holdFull),
    .txAPos(txAPos), .txANeg(txANeg), .txBPos(txBPos), .txBNeg(txBNeg),
    .loopA(loopA), .loopB(loopB)
  );
endmodule

// File: tb/tb_biphaseEncoder.sv
module tb_biphaseEncoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] wordIn = '0;
  logic        syncIsCmd = 1'b0, start = 1'b0, selfTest = 1'b0;
  logic        testSelA = 1'b0, chanAEn = 1'b0, chanBEn = 1'b0;
  logic        txAPos, txANeg, txBPos, txBNeg, loopA, loopB, busy, done;
  int          checks = 0, errors = 0;

  localparam int FRAME_CLKS = 240;

  always #10 clk = ~clk;

  biphaseEncoder dut (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .syncIsCmd(syncIsCmd),
    .start(start), .selfTest(selfTest), .testSelA(testSelA),
    .chanAEn(chanAEn), .chanBEn(chanBEn), .txAPos(txAPos), .txANeg(txANeg),
    .txBPos(txBPos), .txBNeg(txBNeg), .loopA(loopA), .loopB(loopB),
    .busy(busy), .done(done)
  );

  wire [5:0] obs = {txAPos, txANeg, txBPos, txBNeg, loopA, loopB};

  // route codes: 0 none, 1 line A, 2 line B, 3 loop A, 4 loop B
  function automatic int expRoute(logic st, logic sel, logic ea, logic eb);
    if (st) return sel ? 3 : 4;
    if (ea) return 1;
    if (eb) return 2;
    return 0;
  endfunction

  function automatic logic expLine(logic [15:0] w, logic cmd, int k);
    int h = k / 6;
    logic b;
    if (h < 3) return cmd;
    if (h < 6) return !cmd;
    if (h < 38) begin
      b = w[15 - (h - 6) / 2];
      return ((h - 6) % 2 == 1) ? !b : b;
    end
    b = ~^w;
    return (h == 39) ? !b : b;
  endfunction

  function automatic logic [5:0] expVec(int r, logic v);
    case (r)
      1: return {v, !v, 4'b0000};
      2: return {2'b00, v, !v, 2'b00};
      3: return {4'b0000, v, 1'b0};
      4: return {5'b00000, v};
      default: return 6'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at the negedge of the frame's first cycle; returns at the negedge after it
  task automatic checkFrame(input logic [15:0] w, input logic cmd, input int r,
                            input int flipAt, input string req);
    int bad = 0, badBusy = 0;
    logic [5:0] fa = '0, fe = '0, e;
    for (int k = 0; k < FRAME_CLKS; k++) begin
      if (k == flipAt) begin
        selfTest = ~selfTest; testSelA = ~testSelA;
        chanAEn = ~chanAEn;   chanBEn = ~chanBEn;
      end
      e = expVec(r, expLine(w, cmd, k));
      if (obs !== e) begin
        if (bad == 0) begin fa = obs; fe = e; end
        bad++;
      end
      if (busy !== 1'b1) badBusy++;
      @(negedge clk);
    end
    check(bad == 0, req, "frame waveform", {26'd0, fa}, {26'd0, fe});
    check(badBusy == 0, "R2", "busy during frame", badBusy, 0);
    check(done === 1'b1, "R12", "done after parity", done, 1);
  endtask

  task automatic idleCheck(input int n, input string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      if (obs !== 6'b0 || busy !== 1'b0 || (k > 0 && done !== 1'b0)) bad++;
      @(negedge clk);
    end
    check(bad == 0, req, "idle null", bad, 0);
  endtask

  // Called at a negedge
  task automatic runOne(input logic [15:0] w, input logic cmd, input logic st,
                        input logic sel, input logic ea, input logic eb,
                        input int flipAt, input string req);
    int r = expRoute(st, sel, ea, eb);
    selfTest = st; testSelA = sel; chanAEn = ea; chanBEn = eb;
    wordIn = w; syncIsCmd = cmd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    checkFrame(w, cmd, r, flipAt, req);
    check(busy === 1'b0, "R12", "busy low after frame", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'd1553));
    repeat (3) @(negedge clk);
    check(obs === 6'b0 && busy === 1'b0 && done === 1'b0, "R1", "in reset",
          {busy, done, obs}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(obs === 6'b0 && busy === 1'b0 && done === 1'b0, "R1", "after reset",
          {busy, done, obs}, 0);

    // R3 R4 R5 directed patterns
    runOne(16'hA5C3, 1'b1, 0, 0, 1, 0, -1, "R3");
    runOne(16'h0000, 1'b0, 0, 0, 0, 1, -1, "R5");
    runOne(16'hFFFF, 1'b1, 0, 0, 1, 1, -1, "R4");
    runOne(16'h0001, 1'b0, 0, 0, 0, 1, -1, "R5");
    runOne(16'h8000, 1'b1, 0, 0, 1, 0, -1, "R6");
    // R7 both enables prefer A, none gives no output
    runOne(16'h1234, 1'b1, 0, 1, 1, 1, -1, "R7");
    runOne(16'h4321, 1'b0, 0, 1, 0, 0, -1, "R7");
    // R8 loopback selection, external lines quiet
    runOne(16'hBEEF, 1'b1, 1, 1, 1, 1, -1, "R8");
    runOne(16'h0F0F, 1'b0, 1, 0, 1, 1, -1, "R8");
    // R9 controls toggled mid-frame
    runOne(16'h5A5A, 1'b1, 0, 0, 1, 0, 100, "R9");
    runOne(16'hC001, 1'b0, 1, 1, 0, 0, 77, "R9");
    idleCheck(20, "R6");

    // R10 back-to-back, R11 third start dropped
    selfTest = 0; testSelA = 0; chanAEn = 0; chanBEn = 1;
    wordIn = 16'h6B2D; syncIsCmd = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    fork
      checkFrame(16'h6B2D, 1'b1, 2, -1, "R10");
      begin
        repeat (5) @(negedge clk);
        wordIn = 16'h9E71; syncIsCmd = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        wordIn = 16'h3333; syncIsCmd = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    checkFrame(16'h9E71, 1'b0, 2, -1, "R10");
    check(busy === 1'b0, "R12", "busy low after second frame", busy, 0);
    idleCheck(300, "R11");

    // random frames
    for (int i = 0; i < 16; i++) begin
      logic c, st, sel, ea, eb;
      w = 16'($urandom);
      c = 1'($urandom); st = 1'($urandom); sel = 1'($urandom);
      ea = 1'($urandom); eb = 1'($urandom);
      runOne(w, c, st, sel, ea, eb, (i % 3 == 0) ? int'($urandom % 240) : -1,
             st ? "R8" : "R7");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule